// File: doc/BRIEF.md
# Binary Convolution Popcount Threshold Unit

This block produces one output bit of a binarized convolution layer. Parallelism runs along the input-channel axis: every valid beat carries one bit per input channel for a single kernel position, as a 64-bit activation word and a 64-bit weight word. The unit marks the channels where the two bits agree (XNOR). It counts the agreeing bits with 8-bit lookup-table slices feeding a registered adder tree. Each kernel position then adds a signed term, twice the count minus the channel width, to a window accumulator.

A window opens on a beat flagged first and closes on a beat flagged last, so one piece of hardware serves any kernel size up to nine positions. On the closing beat the unit takes a signed bias. Batch normalization and the sign function are folded into one signed comparison against that bias, so the datapath has no multiplier. The result is a one-cycle valid pulse carrying the output bit and the signed dot product.

Top module: `bin_conv_thresh`

## Requirements
- R1: While reset is asserted and after its release, until the first result arrives, valid_o, bit_o and dot_o are all zero.
- R2: A channel counts as a match when its activation bit equals its weight bit. Each beat adds 2*matches - 64 to the window sum, so dot_o is always even.
- R3: All 64 channels are counted, in eight 8-bit slices at bit offsets 0, 8, ..., 56. A beat whose only matches are the eight bits of one slice contributes -48, whichever slice it is.
- R4: A valid beat with first_i high discards any partial sum and starts a new window. Later valid beats add to the sum. A window abandoned without a last beat produces no result.
- R5: valid_o is a single-cycle pulse. It rises after the fourth rising edge counted from the edge that samples a valid last beat, counting that edge as the first, and never appears otherwise.
- R6: bit_o is 1 exactly when dot_o >= bias as signed 16-bit numbers, equality included. The bias used is the one presented with the last beat; bias on other beats has no effect.
- R7: The 16-bit signed sum does not overflow for windows of up to nine positions. It reaches +576 for nine all-matching beats and -576 for nine all-mismatching beats.
- R8: Cycles with valid_i low leave the sum and outputs untouched, whatever the data, flag and bias inputs carry.
- R9: A beat with both first_i and last_i high is a complete one-position window.
- R10: Windows may follow each other with no idle cycle, including a stream of single-position windows, one per clock. Each window yields its own result in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Beat valid |
| first_i | input | 1 | Beat opens a window |
| last_i | input | 1 | Beat closes a window |
| act_i | input | 64 | Binary activations, one bit per input channel |
| wgt_i | input | 64 | Binary weights, one bit per input channel |
| bias_i | input | 16 | Signed threshold, taken with the last beat |
| valid_o | output | 1 | Result pulse |
| bit_o | output | 1 | Binarized output |
| dot_o | output | 16 | Signed dot product of the closed window |

## Verification
Opening and closing a window can fall in the same accumulator cycle: a beat flagged both first and last must clear the sum and capture the result at once. Close and reopen also land on adjacent cycles when windows are packed back to back. The bench provokes both with a run of single-beat windows, one per clock, each with its own bias, and with multi-beat windows that start in the cycle after the previous last beat. Each pulse is compared in order against a reference built from $countones of the XNOR vector. The number of pulses must equal the number of windows sent.

// File: rtl/bcpt_pkg.sv
package bcpt_pkg;
  localparam int SLICE_W     = 8;
  localparam int SLICE_CNT_W = 4;
  localparam int LUT_BITS    = (1 << SLICE_W) * SLICE_CNT_W;

  // bit-count table for one slice, entry i at bits [i*4 +: 4]
  function automatic logic [LUT_BITS-1:0] build_lut();
    logic [LUT_BITS-1:0] t;
    int c;
    t = '0;
    for (int i = 0; i < (1 << SLICE_W); i++) begin
      c = 0;
      for (int b = 0; b < SLICE_W; b++) c += (i >> b) & 1;
      t[i*SLICE_CNT_W +: SLICE_CNT_W] = SLICE_CNT_W'(c);
    end
    return t;
  endfunction

  localparam logic [LUT_BITS-1:0] SLICE_LUT = build_lut();
endpackage

// File: rtl/bcpt_slice_lut.sv
module bcpt_slice_lut
  import bcpt_pkg::*;
(
  input  logic [SLICE_W-1:0]     bits_i,
  output logic [SLICE_CNT_W-1:0] cnt_o
);
  assign cnt_o = SLICE_LUT[int'(bits_i)*SLICE_CNT_W +: SLICE_CNT_W];
endmodule

// File: rtl/bcpt_popcnt_tree.sv
module bcpt_popcnt_tree
  import bcpt_pkg::*;
#(
  parameter int N_CH   = 64,
  parameter int BIAS_W = 16,
  parameter int CNT_W  = $clog2(N_CH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     first_i,
  input  logic                     last_i,
  input  logic signed [BIAS_W-1:0] bias_i,
  input  logic [N_CH-1:0]          match_i,
  output logic                     valid_o,
  output logic                     first_o,
  output logic                     last_o,
  output logic signed [BIAS_W-1:0] bias_o,
  output logic [CNT_W-1:0]         cnt_o
);
  localparam int N_SL   = N_CH / SLICE_W;
  localparam int LEVELS = $clog2(N_SL);

  logic [SLICE_CNT_W-1:0] leaf   [N_SL];
  logic [CNT_W-1:0]       heap_q [1:N_SL-1];
  logic [CNT_W-1:0]       node   [2:2*N_SL-1];

  for (genvar s = 0; s < N_SL; s++) begin : g_slice
    bcpt_slice_lut u_lut (
      .bits_i(match_i[s*SLICE_W +: SLICE_W]),
      .cnt_o (leaf[s])
    );
  end

  // heap layout: node k has children 2k and 2k+1, leaves at N_SL..2*N_SL-1
  for (genvar k = 2; k < 2*N_SL; k++) begin : g_node
    if (k >= N_SL) begin : g_leaf
      assign node[k] = CNT_W'(leaf[k-N_SL]);
    end else begin : g_inner
      assign node[k] = heap_q[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i < N_SL; i++) heap_q[i] <= '0;
    end else begin
      for (int i = 1; i < N_SL; i++) heap_q[i] <= node[2*i] + node[2*i+1];
    end
  end

  logic [LEVELS-1:0]        v_q, f_q, l_q;
  logic signed [BIAS_W-1:0] b_q [LEVELS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      f_q <= '0;
      l_q <= '0;
      for (int l = 0; l < LEVELS; l++) b_q[l] <= '0;
    end else begin
      v_q[0] <= valid_i;
      f_q[0] <= valid_i & first_i;
      l_q[0] <= valid_i & last_i;
      b_q[0] <= bias_i;
      for (int l = 1; l < LEVELS; l++) begin
        v_q[l] <= v_q[l-1];
        f_q[l] <= f_q[l-1];
        l_q[l] <= l_q[l-1];
        b_q[l] <= b_q[l-1];
      end
    end
  end

  assign valid_o = v_q[LEVELS-1];
  assign first_o = f_q[LEVELS-1];
  assign last_o  = l_q[LEVELS-1];
  assign bias_o  = b_q[LEVELS-1];
  assign cnt_o   = heap_q[1];
endmodule

// File: rtl/bcpt_acc_thresh.sv
module bcpt_acc_thresh #(
  parameter int N_CH   = 64,
  parameter int CNT_W  = $clog2(N_CH + 1),
  parameter int ACC_W  = 16,
  parameter int BIAS_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     first_i,
  input  logic                     last_i,
  input  logic signed [BIAS_W-1:0] bias_i,
  input  logic [CNT_W-1:0]         cnt_i,
  output logic                     valid_o,
  output logic                     bit_o,
  output logic signed [ACC_W-1:0]  dot_o
);
  logic signed [ACC_W-1:0] acc_q, term, acc_nx;

  // signed +/-1 dot product of one beat: 2*matches - N_CH
  assign term   = $signed(ACC_W'({cnt_i, 1'b0})) - $signed(ACC_W'(N_CH));
  assign acc_nx = (first_i ? '0 : acc_q) + term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      valid_o <= 1'b0;
      bit_o   <= 1'b0;
      dot_o   <= '0;
    end else begin
      valid_o <= valid_i & last_i;
      if (valid_i) acc_q <= acc_nx;
      if (valid_i && last_i) begin
        dot_o <= acc_nx;
        bit_o <= (acc_nx >= bias_i);
      end
    end
  end
endmodule

// File: rtl/bin_conv_thresh.sv
module bin_conv_thresh #(
  parameter int N_CH   = 64,
  parameter int ACC_W  = 16,
  parameter int BIAS_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     first_i,
  input  logic                     last_i,
  input  logic [N_CH-1:0]          act_i,
  input  logic [N_CH-1:0]          wgt_i,
  input  logic signed [BIAS_W-1:0] bias_i,
  output logic                     valid_o,
  output logic                     bit_o,
  output logic signed [ACC_W-1:0]  dot_o
);
  localparam int CNT_W = $clog2(N_CH + 1);

  logic [N_CH-1:0]          match;
  logic                     t_valid, t_first, t_last;
  logic signed [BIAS_W-1:0] t_bias;
  logic [CNT_W-1:0]         t_cnt;

  assign match = ~(act_i ^ wgt_i);

  bcpt_popcnt_tree #(.N_CH(N_CH), .BIAS_W(BIAS_W), .CNT_W(CNT_W)) u_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .first_i(first_i),
    .last_i (last_i),
    .bias_i (bias_i),
    .match_i(match),
    .valid_o(t_valid),
    .first_o(t_first),
    .last_o (t_last),
    .bias_o (t_bias),
    .cnt_o  (t_cnt)
  );

  bcpt_acc_thresh #(.N_CH(N_CH), .CNT_W(CNT_W), .ACC_W(ACC_W), .BIAS_W(BIAS_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(t_valid),
    .first_i(t_first),
    .last_i (t_last),
    .bias_i (t_bias),
    .cnt_i  (t_cnt),
    .valid_o(valid_o),
    .bit_o  (bit_o),
    .dot_o  (dot_o)
  );
endmodule

// File: rtl/bcpt_chk.sv
module bcpt_chk #(
  parameter int N_CH    = 64,
  parameter int ACC_W   = 16,
  parameter int BIAS_W  = 16,
  parameter int MAX_POS = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              last_i,
  input logic [BIAS_W-1:0] bias_i,
  input logic              valid_o,
  input logic              bit_o,
  input logic [ACC_W-1:0]  dot_o
);
  localparam int LIMIT = N_CH * MAX_POS;

  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && last_i |-> ##4 valid_o);

  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i && last_i, 4));

  a_r6_threshold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (bit_o == ($signed(dot_o) >= $signed($past(bias_i, 4)))));

  a_r2_even_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !dot_o[0]);

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'($signed(dot_o)) <= LIMIT && int'($signed(dot_o)) >= -LIMIT));
endmodule

bind bin_conv_thresh bcpt_chk #(.N_CH(N_CH), .ACC_W(ACC_W), .BIAS_W(BIAS_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .last_i (last_i),
  .bias_i (bias_i),
  .valid_o(valid_o),
  .bit_o  (bit_o),
  .dot_o  (dot_o)
);

// File: tb/sim_bin_conv_thresh.sv
`timescale 1ns/1ps
module sim_bin_conv_thresh;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, first = 1'b0, last = 1'b0;
  logic [63:0] act = '0, wgt = '0;
  logic signed [15:0] bias = '0;
  logic valid_o, bit_o;
  logic signed [15:0] dot_o;

  int n_chk = 0, n_err = 0;
  int got_dot[$], exp_dot[$];
  bit got_bit[$], exp_bit[$];

  always #2.5 clk = ~clk;

  bin_conv_thresh u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .first_i(first), .last_i(last),
    .act_i(act), .wgt_i(wgt), .bias_i(bias),
    .valid_o(valid_o), .bit_o(bit_o), .dot_o(dot_o)
  );

  always @(negedge clk)
    if (rst_n && valid_o) begin
      got_dot.push_back(int'(dot_o));
      got_bit.push_back(bit_o);
    end

  task automatic check(string req, int act_v, int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  function automatic int contrib(logic [63:0] a, logic [63:0] w);
    return 2 * $countones(~(a ^ w)) - 64;
  endfunction

  task automatic beat(logic [63:0] a, logic [63:0] w, bit f, bit l, int b);
    @(negedge clk);
    valid = 1'b1; first = f; last = l; act = a; wgt = w; bias = 16'(b);
  endtask

  // idle cycle with garbage on data, flags and bias (R8)
  task automatic idle_noise();
    @(negedge clk);
    valid = 1'b0; first = 1'($urandom); last = 1'($urandom);
    act = {$urandom, $urandom}; wgt = {$urandom, $urandom};
    bias = 16'($urandom);
  endtask

  task automatic quiet();
    @(negedge clk);
    valid = 1'b0; first = 1'b0; last = 1'b0;
  endtask

  task automatic expect_res(int d, int b);
    exp_dot.push_back(d);
    exp_bit.push_back(d >= b);
  endtask

  task automatic drain(string req);
    quiet();
    repeat (6) @(negedge clk);
    check({req, " result count"}, got_dot.size(), exp_dot.size());
    while (got_dot.size() > 0 && exp_dot.size() > 0) begin
      check({req, " dot_o"}, got_dot.pop_front(), exp_dot.pop_front());
      check({req, " bit_o"}, int'(got_bit.pop_front()), int'(exp_bit.pop_front()));
    end
    got_dot.delete(); got_bit.delete(); exp_dot.delete(); exp_bit.delete();
  endtask

  // mode 0 random bias, 1 equal to sum, 2 sum+1, 3 sum-1
  task automatic window(int npos, int mode, bit gaps);
    logic [63:0] a, w;
    int sum = 0, b;
    for (int p = 0; p < npos; p++) begin
      a = {$urandom, $urandom}; w = {$urandom, $urandom};
      sum += contrib(a, w);
      case (mode)
        1: b = sum;
        2: b = sum + 1;
        3: b = sum - 1;
        default: b = int'($urandom_range(600)) - 300;
      endcase
      if (p != npos - 1) b = int'($urandom_range(2000)) - 1000;
      beat(a, w, p == 0, p == npos - 1, b);
      if (gaps) repeat ($urandom_range(2)) idle_noise();
      if (p == npos - 1) expect_res(sum, b);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 valid_o in reset", int'(valid_o), 0);
    check("R1 bit_o in reset", int'(bit_o), 0);
    check("R1 dot_o in reset", int'(dot_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid_o after reset", int'(valid_o), 0);
    check("R1 dot_o after reset", int'(dot_o), 0);
  endtask

  task automatic t_latency();
    beat(64'h0123_4567_89ab_cdef, 64'h0123_4567_89ab_cdef, 1, 1, 64);
    expect_res(64, 64);
    for (int k = 1; k <= 5; k++) begin
      if (k == 1) quiet(); else @(negedge clk);
      check($sformatf("R5 valid_o %0d cycles after", k), int'(valid_o), int'(k == 4));
    end
    drain("R5");
  endtask

  task automatic t_extremes();
    for (int p = 0; p < 9; p++) beat(64'hdead_beef_0bad_f00d, 64'hdead_beef_0bad_f00d, p == 0, p == 8, 576);
    expect_res(576, 576);
    for (int p = 0; p < 9; p++) beat(64'h5555_0000_ffff_1234, ~64'h5555_0000_ffff_1234, p == 0, p == 8, -575);
    expect_res(-576, -575);
    drain("R7 R6 extremes");
  endtask

  task automatic t_slices();
    for (int s = 0; s < 8; s++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] m = 64'hff << (8 * s);
      beat(a, ~a ^ m, 1, 1, -48);
      expect_res(-48, -48);
    end
    drain("R3 slices");
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) window(1 + int'($urandom_range(8)), i % 4, 1'b0);
    drain("R2 R4 R6 random");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 15; i++) begin
      window(1 + int'($urandom_range(8)), i % 4, 1'b1);
      idle_noise();
    end
    drain("R8 gaps");
  endtask

  task automatic t_restart();
    beat({$urandom, $urandom}, {$urandom, $urandom}, 1, 0, 0);
    beat({$urandom, $urandom}, {$urandom, $urandom}, 0, 0, 0);
    window(3, 1, 1'b0);
    idle_noise();
    beat(64'h0, 64'h0, 0, 0, 0);
    window(2, 3, 1'b0);
    drain("R4 restart");
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 20; i++) window(1, i % 4, 1'b0);
    for (int i = 0; i < 10; i++) window(2 + int'($urandom_range(7)), i % 4, 1'b0);
    drain("R9 R10 back-to-back");
  endtask

  initial begin
    t_reset();
    t_latency();
    t_extremes();
    t_slices();
    t_random();
    t_gaps();
    t_restart();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule